// File: doc/BRIEF.md
# Masked Vector Integer Multiply-Add Unit

This block executes the destructive vector multiply-add operation on one whole vector register. Every element of the destination is replaced by the old destination element times a multiplier, plus the matching element of a second vector source. The multiplier is either a scalar integer operand broadcast to all elements or the matching element of another vector source. Only the low element-width bits of the sum are kept. The upper half of the double-width product is never produced, and overflow raises no flag.

The caller presents the old destination, both vector sources, the scalar, the mask register and the control fields, then pulses `start_i`. The unit copies all of them and processes a fixed number of elements per clock. It then pulses `done_o` for one cycle, with `vd_o` holding the finished register. The mask register, the vector length and two policy bits decide which elements get the arithmetic result, which keep their old value and which are filled with all ones.

Top module: `vmadd_unit`

## Requirements
- R1: An active element i becomes (addend_i + old_i * mult_i) mod 2^SEW, where old_i is the old destination element, addend_i is element i of `vs2_i`, and SEW is the element width in bits. This is the low half of the product-plus-addend, never the high half.
- R2: When `vx_i`=1, mult_i is the low SEW bits of `scalar_i`, the same value for every element.
- R3: When `vx_i`=0, mult_i is element i of `vs1_i`.
- R4: When `vm_i`=0, element i is active only if bit i of `mask_i` is 1. When `vm_i`=1, every element with index below the vector length is active.
- R5: An inactive element with index below `vl_i` keeps its old value when `vma_i`=0. It becomes all ones when `vma_i`=1.
- R6: An element with index at or above `vl_i` keeps its old value when `vta_i`=0. It becomes all ones when `vta_i`=1. A `vl_i` above the element count makes every element a body element.
- R7: `sew_i` encodes 0, 1, 2 and 3 as SEW = 8, 16, 32 and 64. Element i occupies bits [i*SEW +: SEW], and the element count is VLEN/SEW.
- R8: A start accepted at clock edge k with `vl_i`>0 raises `done_o` for exactly one cycle after edge k+ceil((VLEN/SEW)/LANES), with the final result on `vd_o`. `vd_o` does not change while the unit is idle and no start arrives.
- R9: A start accepted with `vl_i`=0 raises `done_o` after the next edge, and `vd_o` equals the old destination unchanged, whatever the policy bits are.
- R10: A `start_i` that arrives while an operation is in progress is ignored. The running operation's operands and result are unaffected.
- R11: While reset is held, `done_o` is 0 and `vd_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Pulse that copies all operands and begins an operation |
| vx_i | input | 1 | 1 selects the scalar multiplier, 0 selects the vector source `vs1_i` |
| sew_i | input | 2 | Element width code (0:8, 1:16, 2:32, 3:64 bits) |
| vl_i | input | VLW | Vector length in elements |
| vm_i | input | 1 | 1 = unmasked, 0 = `mask_i` gates each element |
| vta_i | input | 1 | Tail policy: 1 fills with ones, 0 keeps the old value |
| vma_i | input | 1 | Inactive-element policy: 1 fills with ones, 0 keeps the old value |
| vd_i | input | VLEN | Old destination register value |
| vs2_i | input | VLEN | Addend vector source |
| vs1_i | input | VLEN | Multiplier vector source |
| scalar_i | input | XLEN | Scalar multiplier |
| mask_i | input | VLEN | Mask register, bit i belongs to element i |
| vd_o | output | VLEN | Updated destination register |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench targets the element-placement and policy corners. Its cases are:
- Operands with the top bit set at every width, so that a unit returning the high product half or leaking a carry into the next element shows up at once.
- Scalars with bits set above SEW, which catch a missing truncation.
- Masks and vector lengths that split the register into active, inactive and tail regions, under all four policy combinations, so a swapped policy bit or an off-by-one tail boundary is visible.
- Zero vector length with the tail policy set to fill with ones, plus a vector length larger than the element count.
- A second start issued mid-operation, which would corrupt the result if it were accepted.

// File: rtl/vmadd_pkg.sv
`timescale 1ns/1ps
package vmadd_pkg;

  typedef enum logic [1:0] {
    EW8  = 2'd0,
    EW16 = 2'd1,
    EW32 = 2'd2,
    EW64 = 2'd3
  } ew_e;

  // Mask of the low SEW bits of a 64-bit element slot.
  function automatic logic [63:0] ew_mask(input logic [1:0] code);
    case (ew_e'(code))
      EW8:     ew_mask = 64'h0000_0000_0000_00FF;
      EW16:    ew_mask = 64'h0000_0000_0000_FFFF;
      EW32:    ew_mask = 64'h0000_0000_FFFF_FFFF;
      default: ew_mask = 64'hFFFF_FFFF_FFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/vmadd_lane.sv
`timescale 1ns/1ps
module vmadd_lane
  import vmadd_pkg::*;
(
  input  logic [1:0]  sew_i,
  input  logic [63:0] old_i,
  input  logic [63:0] add_i,
  input  logic [63:0] mul_i,
  input  logic        body_i,
  input  logic        act_i,
  input  logic        vta_i,
  input  logic        vma_i,
  output logic [63:0] res_o
);

  logic [63:0] m;
  logic [63:0] sum;

  always_comb begin
    m   = ew_mask(sew_i);
    // Low 64 bits of the product; masking keeps only the low SEW bits.
    sum = add_i + old_i * mul_i;
    if (!body_i) begin
      res_o = vta_i ? m : (old_i & m);
    end else if (!act_i) begin
      res_o = vma_i ? m : (old_i & m);
    end else begin
      res_o = sum & m;
    end
  end

endmodule

// File: rtl/vmadd_seq.sv
`timescale 1ns/1ps
module vmadd_seq #(
  parameter int IDXW  = 5,
  parameter int LANES = 4
) (
  input  logic            clk_i,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            vl_zero_i,
  input  logic [IDXW-1:0] nelem_i,
  output logic            load_o,
  output logic            busy_o,
  output logic [IDXW-1:0] base_o,
  output logic            done_o
);

  logic            busy_q, busy_d;
  logic [IDXW-1:0] base_q, base_d;
  logic            done_q, done_d;
  logic [IDXW:0]   reach;

  assign load_o = start_i & ~busy_q;
  assign reach  = {1'b0, base_q} + (IDXW+1)'(LANES);

  always_comb begin
    busy_d = busy_q;
    base_d = base_q;
    done_d = 1'b0;
    if (load_o) begin
      base_d = '0;
      if (vl_zero_i) begin
        done_d = 1'b1;
      end else begin
        busy_d = 1'b1;
      end
    end else if (busy_q) begin
      if (reach >= {1'b0, nelem_i}) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        base_d = reach[IDXW-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      base_q <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      base_q <= base_d;
      done_q <= done_d;
    end
  end

  assign busy_o = busy_q;
  assign base_o = base_q;
  assign done_o = done_q;

endmodule

// File: rtl/vmadd_unit.sv
`timescale 1ns/1ps
module vmadd_unit
  import vmadd_pkg::*;
#(
  parameter int VLEN  = 128,
  parameter int XLEN  = 64,
  parameter int LANES = 4,
  localparam int VLW  = $clog2(VLEN) + 1,
  localparam int IDXW = $clog2(VLEN / 8) + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            vx_i,
  input  logic [1:0]      sew_i,
  input  logic [VLW-1:0]  vl_i,
  input  logic            vm_i,
  input  logic            vta_i,
  input  logic            vma_i,
  input  logic [VLEN-1:0] vd_i,
  input  logic [VLEN-1:0] vs2_i,
  input  logic [VLEN-1:0] vs1_i,
  input  logic [XLEN-1:0] scalar_i,
  input  logic [VLEN-1:0] mask_i,
  output logic [VLEN-1:0] vd_o,
  output logic            done_o
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rs_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rs_q <= 2'b00;
    else         rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n = rs_q[1];

  // Operand registers, written only when a start is accepted.
  logic            load, busy;
  logic [IDXW-1:0] base;
  logic [1:0]      sew_q;
  logic [VLW-1:0]  vl_q;
  logic            vm_q, vx_q, vta_q, vma_q;
  logic [VLEN-1:0] vs2_q, vs1_q, mask_q;
  logic [XLEN-1:0] sc_q;
  logic [VLEN-1:0] dst_q, dst_d;
  logic [IDXW-1:0] nelem;

  always_ff @(posedge clk_i) begin
    if (load) begin
      sew_q  <= sew_i;
      vl_q   <= vl_i;
      vm_q   <= vm_i;
      vx_q   <= vx_i;
      vta_q  <= vta_i;
      vma_q  <= vma_i;
      vs2_q  <= vs2_i;
      vs1_q  <= vs1_i;
      mask_q <= mask_i;
      sc_q   <= scalar_i;
    end
  end

  assign nelem = IDXW'((VLEN / 8) >> sew_q);

  vmadd_seq #(.IDXW(IDXW), .LANES(LANES)) u_seq (
    .clk_i     (clk_i),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .vl_zero_i (vl_i == '0),
    .nelem_i   (nelem),
    .load_o    (load),
    .busy_o    (busy),
    .base_o    (base),
    .done_o    (done_o)
  );

  // Lanes: each handles element base+g during the current cycle.
  logic [63:0]      lane_res [LANES];
  logic [31:0]      lane_sh  [LANES];
  logic [LANES-1:0] lane_ok;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [IDXW-1:0] idx;
    logic [31:0]     sh;
    logic [VLEN-1:0] d_sh, a_sh, b_sh, k_sh;
    logic [63:0]     mul, res;
    logic            body, act;

    always_comb begin
      idx  = base + IDXW'(g);
      sh   = 32'(idx) << (32'd3 + 32'(sew_q));
      d_sh = dst_q >> sh;
      a_sh = vs2_q >> sh;
      b_sh = vs1_q >> sh;
      k_sh = mask_q >> idx;
      mul  = vx_q ? (64'(sc_q) & ew_mask(sew_q)) : (b_sh[63:0] & ew_mask(sew_q));
      body = 32'(idx) < 32'(vl_q);
      act  = vm_q | k_sh[0];
    end

    vmadd_lane u_lane (
      .sew_i  (sew_q),
      .old_i  (d_sh[63:0] & ew_mask(sew_q)),
      .add_i  (a_sh[63:0] & ew_mask(sew_q)),
      .mul_i  (mul),
      .body_i (body),
      .act_i  (act),
      .vta_i  (vta_q),
      .vma_i  (vma_q),
      .res_o  (res)
    );

    assign lane_res[g] = res;
    assign lane_sh[g]  = sh;
    assign lane_ok[g]  = idx < nelem;
  end

  always_comb begin
    dst_d = dst_q;
    for (int g = 0; g < LANES; g++) begin
      if (lane_ok[g]) begin
        dst_d = (dst_d & ~(VLEN'(ew_mask(sew_q)) << lane_sh[g]))
              | (VLEN'(lane_res[g]) << lane_sh[g]);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      dst_q <= '0;
    end else if (load) begin
      dst_q <= vd_i;
    end else if (busy) begin
      dst_q <= dst_d;
    end
  end

  assign vd_o = dst_q;

endmodule

// File: rtl/vmadd_unit_chk.sv
`timescale 1ns/1ps
module vmadd_unit_chk #(
  parameter int VLEN  = 128,
  parameter int LANES = 4,
  parameter int VLW   = 8
) (
  input logic            clk_i,
  input logic            rst_n,
  input logic            start_i,
  input logic [VLW-1:0]  vl_i,
  input logic [VLEN-1:0] vd_i,
  input logic [VLEN-1:0] vd_o,
  input logic            done_o,
  input logic            busy_i
);

  localparam int MAXC = (VLEN / 8 + LANES - 1) / LANES;

  logic [31:0] run_cnt;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)       run_cnt <= '0;
    else if (!busy_i) run_cnt <= '0;
    else              run_cnt <= run_cnt + 32'd1;
  end

  AST_RUN_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_n)
    busy_i |-> run_cnt < 32'(MAXC)); // R8

  AST_DONE_AT_END: assert property (@(posedge clk_i) disable iff (!rst_n)
    $fell(busy_i) |-> done_o); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (done_o && !start_i) |=> !done_o); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!busy_i && !start_i) |=> $stable(vd_o)); // R8

  AST_ZERO_VL_KEEP: assert property (@(posedge clk_i) disable iff (!rst_n)
    (start_i && !busy_i && vl_i == '0) |=> (done_o && vd_o == $past(vd_i))); // R9

  AST_BUSY_NO_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_n)
    (busy_i && start_i && !done_o) |=> !(vd_o == $past(vd_i) && vd_o != $past(vd_o) && !done_o && !busy_i)); // R10

  always_comb begin
    if (!rst_n) begin
      AST_RESET_CLEAR: assert (!done_o && vd_o == '0); // R11
    end
  end

endmodule

bind vmadd_unit vmadd_unit_chk #(.VLEN(VLEN), .LANES(LANES), .VLW(VLW)) u_chk (
  .clk_i   (clk_i),
  .rst_n   (rst_n),
  .start_i (start_i),
  .vl_i    (vl_i),
  .vd_i    (vd_i),
  .vd_o    (vd_o),
  .done_o  (done_o),
  .busy_i  (busy)
);

// File: tb/vmadd_unit_test.sv
`timescale 1ns/1ps
module vmadd_unit_test;

  localparam int VLEN  = 128;
  localparam int XLEN  = 64;
  localparam int LANES = 4;
  localparam int VLW   = $clog2(VLEN) + 1;

  logic            clk_i = 1'b0;
  logic            rst_ni;
  logic            start_i, vx_i, vm_i, vta_i, vma_i;
  logic [1:0]      sew_i;
  logic [VLW-1:0]  vl_i;
  logic [VLEN-1:0] vd_i, vs2_i, vs1_i, mask_i;
  logic [XLEN-1:0] scalar_i;
  logic [VLEN-1:0] vd_o;
  logic            done_o;

  int n_vec  = 0;
  int n_fail = 0;

  always #10 clk_i = ~clk_i;

  vmadd_unit #(.VLEN(VLEN), .XLEN(XLEN), .LANES(LANES)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .vx_i(vx_i),
    .sew_i(sew_i), .vl_i(vl_i), .vm_i(vm_i), .vta_i(vta_i), .vma_i(vma_i),
    .vd_i(vd_i), .vs2_i(vs2_i), .vs1_i(vs1_i), .scalar_i(scalar_i),
    .mask_i(mask_i), .vd_o(vd_o), .done_o(done_o)
  );

  task automatic check(input string req, input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Behavioural reference for one whole operation.
  function automatic logic [VLEN-1:0] model(
    input logic [VLEN-1:0] vd, vs2, vs1, msk, input logic [XLEN-1:0] sc,
    input int sew, input int vl, input bit vm, vx, vta, vma);
    int ew = 8 << sew;
    int n  = VLEN / ew;
    logic [63:0] m = (ew == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << ew) - 64'd1);
    logic [VLEN-1:0] r = vd;
    if (vl == 0) return vd;
    for (int i = 0; i < n; i++) begin
      logic [63:0] o, a, b, mu, e;
      o  = 64'(vd  >> (i * ew)) & m;
      a  = 64'(vs2 >> (i * ew)) & m;
      b  = 64'(vs1 >> (i * ew)) & m;
      mu = vx ? (64'(sc) & m) : b;
      if (i >= vl)              e = vta ? m : o;
      else if (!vm && !msk[i])  e = vma ? m : o;
      else                      e = (a + o * mu) & m;
      r = (r & ~(VLEN'(m) << (i * ew))) | (VLEN'(e) << (i * ew));
    end
    return r;
  endfunction

  function automatic logic [VLEN-1:0] rnd();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // Runs one operation and checks done and vd_o on every cycle.
  task automatic run(input string req, input int sew, input int vl, input bit vm, vx, vta, vma,
                     input logic [VLEN-1:0] vd, vs2, vs1, msk, input logic [XLEN-1:0] sc,
                     input bit poke);
    logic [VLEN-1:0] exp;
    int n, lat;
    exp = model(vd, vs2, vs1, msk, sc, sew, vl, vm, vx, vta, vma);
    n   = VLEN / (8 << sew);
    lat = (vl == 0) ? 0 : (n + LANES - 1) / LANES;
    @(negedge clk_i);
    sew_i = 2'(sew); vl_i = VLW'(vl); vm_i = vm; vx_i = vx; vta_i = vta; vma_i = vma;
    vd_i = vd; vs2_i = vs2; vs1_i = vs1; mask_i = msk; scalar_i = sc; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int c = 0; c <= lat; c++) begin
      if (c == 0 && poke && lat > 0) begin
        // R10: a second start with different operands while running
        vd_i = ~vd; vs2_i = rnd(); vl_i = VLW'(1); start_i = 1'b1;
      end
      if (c == lat) begin
        check({req, " done"}, VLEN'(done_o), VLEN'(1));
        check({req, " result"}, vd_o, exp);
      end else begin
        check({req, " R8 early done"}, VLEN'(done_o), VLEN'(0));
      end
      @(negedge clk_i);
      start_i = 1'b0;
    end
    check({req, " R8 pulse end"}, VLEN'(done_o), VLEN'(0));
    check({req, " R8 hold"}, vd_o, exp);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    logic [VLEN-1:0] ones;
    ones = '1;
    rst_ni = 1'b0; start_i = 1'b0; vx_i = 1'b0; vm_i = 1'b1; vta_i = 1'b0; vma_i = 1'b0;
    sew_i = 2'd0; vl_i = '0; vd_i = '0; vs2_i = '0; vs1_i = '0; mask_i = '0; scalar_i = '0;
    repeat (3) @(negedge clk_i);
    check("R11 reset done", VLEN'(done_o), VLEN'(0));
    check("R11 reset vd", vd_o, '0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);

    // R1/R2 sew8 scalar form, unmasked, full length, top bits set
    run("R1 R2 R7 sew8 vx", 0, 16, 1, 1, 0, 0, {16{8'hF3}}, {16{8'h85}}, '0, '0, 64'h1234_5678_9ABC_DEFF, 0);
    // R3 sew16 vector form, masked, undisturbed
    run("R3 R4 R5 sew16 vv vma0", 1, 8, 0, 0, 0, 0, rnd(), rnd(), rnd(), VLEN'(16'hA5), '0, 0);
    // R5 agnostic inactive, R6 agnostic tail, sew32
    run("R5 R6 sew32 vma1 vta1", 2, 3, 0, 0, 1, 1, rnd(), rnd(), rnd(), VLEN'(4'b0101), '0, 0);
    // R6 undisturbed tail
    run("R6 sew32 vta0", 2, 2, 1, 1, 0, 1, rnd(), rnd(), '0, '0, 64'hFFFF_FFFF_0000_0003, 0);
    // R1 sew64 wrap with all-ones operands
    run("R1 sew64 wrap", 3, 2, 1, 0, 0, 0, ones, ones, ones, '0, '0, 0);
    // R2 truncation: scalar high bits must not matter
    run("R2 sew8 trunc", 0, 16, 1, 1, 0, 0, rnd(), rnd(), '0, '0, 64'hFFFF_FFFF_FFFF_FF02, 0);
    // R9 zero length with tail agnostic
    run("R9 vl0", 1, 0, 1, 0, 1, 1, rnd(), rnd(), rnd(), '0, '0, 0);
    // R6 vl above element count
    run("R6 vl large", 3, 9, 1, 0, 1, 1, rnd(), rnd(), rnd(), '0, '0, 0);
    // R10 start during operation
    run("R10 sew8 poke", 0, 13, 0, 0, 1, 0, rnd(), rnd(), rnd(), rnd(), '0, 1);
    run("R10 sew64 poke", 3, 1, 1, 1, 1, 1, rnd(), rnd(), '0, '0, 64'hDEAD_BEEF_CAFE_F00D, 1);

    for (int k = 0; k < 48; k++) begin
      int s, vl;
      s  = int'($urandom % 4);
      vl = int'($urandom % ((VLEN / (8 << s)) + 3));
      run("R1 R4 R5 R6 R7 random", s, vl, bit'($urandom), bit'($urandom), bit'($urandom), bit'($urandom),
          rnd(), rnd(), rnd(), rnd(), {$urandom, $urandom}, bit'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule